// File: doc/BRIEF.md
# Indexed Register Window with Interrupt Controller

This block gives a host a narrow view onto a large set of internal registers. The host writes a pointer word that holds a channel number and an index. Accesses to the data word then read or write the entry that this pair selects. An array of 64 indices by four channels is held in flops. Two more entries, reachable only on channel 0, form an extended per-stream interrupt pair: a status word and a mask word.

The block also holds a global interrupt pending word and an enable word, with the same bit positions. A host write of 1 clears a pending bit. One pending bit is a summary of the extended status pair: it is set whenever a stream event arrives whose mask bit is on. A single registered request line is raised when any pending bit is also enabled.

The host side is a synchronous strobe bus. One write strobe and one read strobe select one of four words, and the bus carries byte enables. Read data is registered and appears one cycle after the read strobe.

Top module: `ixw_host_regs`

## Requirements
- R1: After reset, the pointer word, the pending word, the enable word, the request line and every array entry (indices 0x00 to 0x3F on all four channels) read zero.
- R2: The pointer word holds the channel in bits [1:0] and the index in bits [27:16]; all other bits read 0. Byte enables 0–1 change only the channel, and byte enables 2–3 change only the index. Word select encoding: 0 pointer, 1 data, 2 pending, 3 enable.
- R3: A data-word access reads or writes the array entry at the selected (channel, index). Each channel has separate storage, and each byte enable gates its own byte.
- R4: An index of 0x40 or above reads zero and ignores writes. This includes the extended pair selected on a non-zero channel. Such writes never alias into the array.
- R5: Writing the pending word clears each bit written as 1 in an enabled byte. Bits written as 0 keep their value.
- R6: A hardware event pulse sets pending bits only at positions 0, 1, 2, 3, 4, 11, 16 and 17. Bit 8 is never set by a hardware event, and all other positions always read 0.
- R7: If a hardware set and a host clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: On channel 0, index 0x75 is a read/write extended mask and index 0x76 is the extended status. Stream events set status bits. A data write of 1 clears a status bit, and a stream event in the same cycle wins over that clear.
- R9: Pending bit 8 is set on the same edge as a stream event that has at least one bit on in the extended mask. An event with no masked-in bit sets status but leaves bit 8 unchanged.
- R10: The request line equals the OR of (pending AND enable) as it stood one clock earlier.
- R11: The enable word is read/write at the implemented positions of R6 plus bit 8; other positions read 0.
- R12: Read data shows the selected word's value from the edge where the read strobe is sampled. It holds unchanged while no read strobe is present, even if registers change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_sel | input | 2 | Word select: 0 pointer, 1 data, 2 pending, 3 enable |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| hw_evt | input | 32 | Hardware interrupt event pulses, one per pending bit |
| ext_evt | input | 32 | Per-stream extended interrupt event pulses |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a set racing a clear on the same bit in the same edge. This applies both to a global pending bit and to an extended status bit whose masked event also feeds the summary bit. The stimulus tasks drive the event pulse and the clearing write in the same low clock phase. The result is then read back through the normal words. Aliasing of out-of-range indices is checked by writing index 0x40 and then reading index 0x00, which shares the same low six bits.

// File: rtl/ixw_pkg.sv
// Shared constants and helpers for the indexed register window.
// Assumes a 32-bit host data path split into byte lanes.
package ixw_pkg;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    // Host word select encoding
    typedef enum logic [1:0] {
        REG_PTR  = 2'd0,
        REG_DATA = 2'd1,
        REG_PEND = 2'd2,
        REG_ENAB = 2'd3
    } reg_sel_e;

    // Positions present in the global pending/enable words
    localparam logic [DATA_W-1:0] IRQ_IMPL_MASK = 32'h0003_091F;
    localparam int                SUMMARY_BIT   = 8;

    // Expand byte enables into a bit mask
    function automatic logic [DATA_W-1:0] be_to_mask(input logic [BE_W-1:0] be);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < BE_W; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction
endpackage

// File: rtl/ixw_ptr_reg.sv
// Pointer word: holds channel and index fields, each updated only by the
// byte lanes that cover it. Spare bits are never stored.
// Assumes the channel field sits at bit 0 and the index at IDX_LSB.
module ixw_ptr_reg
    import ixw_pkg::*;
#(
    parameter int CH_W    = 2,
    parameter int IDX_W   = 12,
    parameter int IDX_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [CH_W-1:0]   ch,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] ptr_word
);
    localparam logic [DATA_W-1:0] CH_FIELD  = DATA_W'((64'd1 << CH_W) - 64'd1);
    localparam logic [DATA_W-1:0] IDX_FIELD = DATA_W'(((64'd1 << IDX_W) - 64'd1) << IDX_LSB);
    localparam logic [DATA_W-1:0] FIELDS    = CH_FIELD | IDX_FIELD;

    logic [DATA_W-1:0] ptr_q;
    logic [DATA_W-1:0] upd_mask;

    assign upd_mask = be_to_mask(be) & FIELDS;

    // Merge enabled lanes of the write into the stored fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (wr) begin
            ptr_q <= (ptr_q & ~upd_mask) | (wdata & upd_mask);
        end
    end

    assign ch       = ptr_q[CH_W-1:0];
    assign idx      = ptr_q[IDX_LSB +: IDX_W];
    assign ptr_word = ptr_q;
endmodule

// File: rtl/ixw_index_file.sv
// Banked indexed register array: one bank of DEPTH words per channel,
// byte-lane writes, combinational read of the selected row.
// Assumes the caller qualifies wr with an in-range index.
module ixw_index_file
    import ixw_pkg::*;
#(
    parameter int CH_W  = 2,
    parameter int DEPTH = 64,
    localparam int AW     = $clog2(DEPTH),
    localparam int NUM_CH = 1 << CH_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CH_W-1:0]   ch,
    input  logic [AW-1:0]     row,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] bank_word [NUM_CH];
    logic [DATA_W-1:0] bmask;

    assign bmask = be_to_mask(be);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
        logic [DATA_W-1:0] mem [DEPTH];

        // Clear the bank on reset, else merge a write aimed at this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < DEPTH; r++) begin
                    mem[r] <= '0;
                end
            end else if (wr && (ch == CH_W'(c))) begin
                mem[row] <= (mem[row] & ~bmask) | (wdata & bmask);
            end
        end

        assign bank_word[c] = mem[row];
    end

    assign rd_word = bank_word[ch];
endmodule

// File: rtl/ixw_ext_irq.sv
// Extended per-stream interrupt pair: a plain mask word and a sticky
// status word with write-one-to-clear. Produces a one-cycle summary set
// pulse when an incoming event hits a masked-in bit.
// Assumes stream events are single-cycle pulses.
module ixw_ext_irq
    import ixw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic              stat_wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] ext_evt,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] stat_q,
    output logic              summary_set
);
    logic [DATA_W-1:0] bmask;
    logic [DATA_W-1:0] clr_vec;

    assign bmask   = be_to_mask(be);
    assign clr_vec = stat_wr ? (wdata & bmask) : '0;

    // Mask word: byte-lane read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= (mask_q & ~bmask) | (wdata & bmask);
        end
    end

    // Status word: events set, host clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | ext_evt;
        end
    end

    assign summary_set = |(ext_evt & mask_q);
endmodule

// File: rtl/ixw_irq_ctrl.sv
// Global interrupt pending/enable words and the registered request line.
// Pending is write-one-to-clear; hardware set beats host clear. The summary
// position is fed only by the extended interrupt unit.
// Assumes event inputs are pulses aligned to clk.
module ixw_irq_ctrl
    import ixw_pkg::*;
#(
    parameter logic [DATA_W-1:0] IMPL_MASK = IRQ_IMPL_MASK,
    parameter int                SUM_BIT   = SUMMARY_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_wr,
    input  logic              enab_wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_evt,
    input  logic              summary_set,
    output logic [DATA_W-1:0] pend_q,
    output logic [DATA_W-1:0] enab_q,
    output logic              irq_q
);
    localparam logic [DATA_W-1:0] SUM_MASK = DATA_W'(1) << SUM_BIT;
    localparam logic [DATA_W-1:0] HW_MASK  = IMPL_MASK & ~SUM_MASK;

    logic [DATA_W-1:0] bmask;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;

    assign bmask   = be_to_mask(be);
    assign set_vec = (hw_evt & HW_MASK) | (summary_set ? SUM_MASK : '0);
    assign clr_vec = pend_wr ? (wdata & bmask) : '0;

    // Pending word update: clear first, then apply sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= ((pend_q & ~clr_vec) | set_vec) & IMPL_MASK;
        end
    end

    // Enable word: byte-lane read/write on implemented positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enab_q <= '0;
        end else if (enab_wr) begin
            enab_q <= ((enab_q & ~bmask) | (wdata & bmask)) & IMPL_MASK;
        end
    end

    // Request line: registered OR of enabled pending bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(pend_q & enab_q);
        end
    end
endmodule

// File: rtl/ixw_host_regs.sv
// Top of the indexed register window. Decodes the four host words, routes
// data-word accesses to the indexed array or the extended interrupt pair,
// and registers the read data.
// Assumes a single-master synchronous strobe bus; a read and a write in
// the same cycle return the value from before the write.
module ixw_host_regs
    import ixw_pkg::*;
#(
    parameter int          CH_W         = 2,
    parameter int          IDX_W        = 12,
    parameter int          IDX_LSB      = 16,
    parameter int          FILE_DEPTH   = 64,
    parameter logic [11:0] EXT_MASK_IDX = 12'h075,
    parameter logic [11:0] EXT_STAT_IDX = 12'h076,
    localparam int         AW           = $clog2(FILE_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_sel,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] hw_evt,
    input  logic [DATA_W-1:0] ext_evt,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    reg_sel_e          sel;
    logic [CH_W-1:0]   cur_ch;
    logic [IDX_W-1:0]  cur_idx;
    logic [DATA_W-1:0] ptr_word;
    logic [DATA_W-1:0] file_word;
    logic [DATA_W-1:0] ext_mask_q;
    logic [DATA_W-1:0] ext_stat_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] enab_q;
    logic [DATA_W-1:0] window_word;
    logic [DATA_W-1:0] rdata_q;
    logic              summary_set;
    logic              file_hit;
    logic              mask_hit;
    logic              stat_hit;
    logic              data_wr;

    assign sel     = reg_sel_e'(bus_sel);
    assign data_wr = bus_wr && (sel == REG_DATA);

    // Index decode: array range, then channel-0-only extended pair
    assign file_hit = (cur_idx < IDX_W'(FILE_DEPTH));
    assign mask_hit = (cur_idx == IDX_W'(EXT_MASK_IDX)) && (cur_ch == '0);
    assign stat_hit = (cur_idx == IDX_W'(EXT_STAT_IDX)) && (cur_ch == '0);

    ixw_ptr_reg #(
        .CH_W    (CH_W),
        .IDX_W   (IDX_W),
        .IDX_LSB (IDX_LSB)
    ) i_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr && (sel == REG_PTR)),
        .be       (bus_be),
        .wdata    (bus_wdata),
        .ch       (cur_ch),
        .idx      (cur_idx),
        .ptr_word (ptr_word)
    );

    ixw_index_file #(
        .CH_W  (CH_W),
        .DEPTH (FILE_DEPTH)
    ) i_file (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (data_wr && file_hit),
        .ch      (cur_ch),
        .row     (cur_idx[AW-1:0]),
        .be      (bus_be),
        .wdata   (bus_wdata),
        .rd_word (file_word)
    );

    ixw_ext_irq i_ext (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr     (data_wr && mask_hit),
        .stat_wr     (data_wr && stat_hit),
        .be          (bus_be),
        .wdata       (bus_wdata),
        .ext_evt     (ext_evt),
        .mask_q      (ext_mask_q),
        .stat_q      (ext_stat_q),
        .summary_set (summary_set)
    );

    ixw_irq_ctrl #(
        .IMPL_MASK (IRQ_IMPL_MASK),
        .SUM_BIT   (SUMMARY_BIT)
    ) i_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_wr     (bus_wr && (sel == REG_PEND)),
        .enab_wr     (bus_wr && (sel == REG_ENAB)),
        .be          (bus_be),
        .wdata       (bus_wdata),
        .hw_evt      (hw_evt),
        .summary_set (summary_set),
        .pend_q      (pend_q),
        .enab_q      (enab_q),
        .irq_q       (irq)
    );

    // Data-word view of the selected entry; unimplemented indices read zero
    always_comb begin
        if (file_hit) begin
            window_word = file_word;
        end else if (mask_hit) begin
            window_word = ext_mask_q;
        end else if (stat_hit) begin
            window_word = ext_stat_q;
        end else begin
            window_word = '0;
        end
    end

    // Read data register: capture the selected word on a read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (sel)
                REG_PTR:  rdata_q <= ptr_word;
                REG_DATA: rdata_q <= window_word;
                REG_PEND: rdata_q <= pend_q;
                REG_ENAB: rdata_q <= enab_q;
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/ixw_checker.sv
// Property checker for the indexed register window, bound into the top.
// Observes host ports plus the pending, enable and extended mask words.
module ixw_checker
    import ixw_pkg::*;
#(
    parameter int CH_W    = 2,
    parameter int IDX_W   = 12,
    parameter int IDX_LSB = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_sel,
    input logic [BE_W-1:0]   bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] hw_evt,
    input logic [DATA_W-1:0] ext_evt,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq,
    input logic [DATA_W-1:0] pend_q,
    input logic [DATA_W-1:0] enab_q,
    input logic [DATA_W-1:0] ext_mask_q
);
    localparam logic [DATA_W-1:0] PTR_FIELDS =
        DATA_W'((64'd1 << CH_W) - 64'd1) | DATA_W'(((64'd1 << IDX_W) - 64'd1) << IDX_LSB);
    localparam logic [DATA_W-1:0] HW_ONLY =
        IRQ_IMPL_MASK & ~(DATA_W'(1) << SUMMARY_BIT);

    AST_IRQ_LAGS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == |($past(pend_q & enab_q)))); // R10

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        |(hw_evt & HW_ONLY) |=> ((pend_q & $past(hw_evt & HW_ONLY)) == $past(hw_evt & HW_ONLY))); // R7

    AST_PEND_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == 2'd2 && hw_evt == '0 && (ext_evt & ext_mask_q) == '0)
        |=> (pend_q == ($past(pend_q) & ~$past(bus_wdata & be_to_mask(bus_be))))); // R5

    AST_SUMMARY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        |(ext_evt & ext_mask_q) |=> pend_q[SUMMARY_BIT]); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata)); // R12

    AST_PTR_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == 2'd0) |=> ((bus_rdata & ~PTR_FIELDS) == '0)); // R2

    AST_ENAB_IMPL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel == 2'd3) |=> ((bus_rdata & ~IRQ_IMPL_MASK) == '0)); // R11
endmodule

bind ixw_host_regs ixw_checker #(
    .CH_W    (CH_W),
    .IDX_W   (IDX_W),
    .IDX_LSB (IDX_LSB)
) i_ixw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_sel    (bus_sel),
    .bus_be     (bus_be),
    .bus_wdata  (bus_wdata),
    .hw_evt     (hw_evt),
    .ext_evt    (ext_evt),
    .bus_rdata  (bus_rdata),
    .irq        (irq),
    .pend_q     (pend_q),
    .enab_q     (enab_q),
    .ext_mask_q (ext_mask_q)
);

// File: tb/test_ixw_host_regs.sv
// Directed bench for the indexed register window: one task per scenario.
module test_ixw_host_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_sel = 2'd0;
    logic [3:0]  bus_be = 4'h0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] hw_evt = '0;
    logic [31:0] ext_evt = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [1:0] S_PTR = 2'd0, S_DATA = 2'd1, S_PEND = 2'd2, S_ENAB = 2'd3;

    always #5 clk = ~clk;

    ixw_host_regs i_ixw_host_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .hw_evt(hw_evt), .ext_evt(ext_evt), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_sel = s; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_be = 4'h0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_sel = s;
        @(posedge clk); #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic point(input logic [1:0] ch, input logic [11:0] idx);
        wr(S_PTR, 4'hF, {4'h0, idx, 14'h0, ch});
    endtask

    task automatic hw_pulse(input logic [31:0] v);
        @(negedge clk);
        hw_evt = v;
        @(posedge clk); #1;
        hw_evt = '0;
    endtask

    task automatic ext_pulse(input logic [31:0] v);
        @(negedge clk);
        ext_evt = v;
        @(posedge clk); #1;
        ext_evt = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        check("R1 irq after reset", {31'h0, irq}, 32'h0);
        rd(S_PTR, d);  check("R1 pointer reset", d, 32'h0);
        rd(S_PEND, d); check("R1 pending reset", d, 32'h0);
        rd(S_ENAB, d); check("R1 enable reset", d, 32'h0);
        point(2'd1, 12'h03F);
        rd(S_DATA, d); check("R1 entry ch1 0x3F reset", d, 32'h0);
        point(2'd3, 12'h000);
        rd(S_DATA, d); check("R1 entry ch3 0x00 reset", d, 32'h0);
    endtask

    task automatic t_pointer;
        logic [31:0] d;
        wr(S_PTR, 4'hF, 32'hFFFF_FFFF);
        rd(S_PTR, d); check("R2 pointer fields only", d, 32'h0FFF_0003);
        wr(S_PTR, 4'b0011, 32'h0000_0000);
        rd(S_PTR, d); check("R2 low lanes change channel only", d, 32'h0FFF_0000);
        wr(S_PTR, 4'b1100, 32'h0005_0002);
        rd(S_PTR, d); check("R2 high lanes change index only", d, 32'h0005_0000);
    endtask

    task automatic t_data;
        logic [31:0] d;
        point(2'd0, 12'h005); wr(S_DATA, 4'hF, 32'h1111_1111);
        point(2'd2, 12'h005); wr(S_DATA, 4'hF, 32'h2222_2222);
        point(2'd0, 12'h005); rd(S_DATA, d); check("R3 ch0 entry", d, 32'h1111_1111);
        point(2'd2, 12'h005); rd(S_DATA, d); check("R3 ch2 entry separate", d, 32'h2222_2222);
        point(2'd0, 12'h005); wr(S_DATA, 4'b0100, 32'hAABB_CCDD);
        rd(S_DATA, d); check("R3 byte lane write", d, 32'h11BB_1111);
        point(2'd3, 12'h03F); wr(S_DATA, 4'hF, 32'hDEAD_BEEF);
        rd(S_DATA, d); check("R3 last index ch3", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_unimpl;
        logic [31:0] d;
        point(2'd0, 12'h040); wr(S_DATA, 4'hF, 32'h1234_5678);
        rd(S_DATA, d); check("R4 index 0x40 reads zero", d, 32'h0);
        point(2'd0, 12'h000); rd(S_DATA, d); check("R4 no alias into 0x00", d, 32'h0);
        point(2'd1, 12'h075); wr(S_DATA, 4'hF, 32'hFFFF_FFFF);
        rd(S_DATA, d); check("R4 mask on ch1 reads zero", d, 32'h0);
        point(2'd0, 12'h075); rd(S_DATA, d); check("R4 ch0 mask untouched", d, 32'h0);
        point(2'd0, 12'hFFF); rd(S_DATA, d); check("R4 top index reads zero", d, 32'h0);
    endtask

    task automatic t_pending;
        logic [31:0] d;
        hw_pulse(32'hFFFF_FFFF);
        rd(S_PEND, d); check("R6 implemented positions only", d, 32'h0003_081F);
        wr(S_PEND, 4'hF, 32'h0000_0003);
        rd(S_PEND, d); check("R5 clear bits 0 and 1", d, 32'h0003_081C);
        wr(S_PEND, 4'hF, 32'h0000_0000);
        rd(S_PEND, d); check("R5 zero write keeps bits", d, 32'h0003_081C);
        wr(S_PEND, 4'b0001, 32'hFFFF_FFFF);
        rd(S_PEND, d); check("R5 byte lane clear", d, 32'h0003_0800);
    endtask

    task automatic t_set_wins;
        logic [31:0] d;
        @(negedge clk);
        hw_evt = 32'h0000_0800;
        bus_wr = 1'b1; bus_sel = S_PEND; bus_be = 4'hF; bus_wdata = 32'h0001_0800;
        @(posedge clk); #1;
        hw_evt = '0; bus_wr = 1'b0;
        rd(S_PEND, d); check("R7 set beats clear", d, 32'h0002_0800);
        wr(S_PEND, 4'hF, 32'hFFFF_FFFF);
        rd(S_PEND, d); check("R5 clear all", d, 32'h0);
    endtask

    task automatic t_enable_irq;
        logic [31:0] d;
        wr(S_ENAB, 4'hF, 32'hFFFF_FFFF);
        rd(S_ENAB, d); check("R11 enable implemented bits", d, 32'h0003_091F);
        wr(S_ENAB, 4'hF, 32'h0000_0001);
        rd(S_ENAB, d); check("R11 enable write back", d, 32'h0000_0001);
        hw_pulse(32'h0000_0008);
        @(posedge clk); #1;
        check("R10 disabled source no request", {31'h0, irq}, 32'h0);
        hw_pulse(32'h0000_0001);
        check("R10 request not yet raised", {31'h0, irq}, 32'h0);
        @(posedge clk); #1;
        check("R10 request one cycle later", {31'h0, irq}, 32'h1);
        wr(S_PEND, 4'hF, 32'h0000_0001);
        check("R10 request still high at clear edge", {31'h0, irq}, 32'h1);
        @(posedge clk); #1;
        check("R10 request dropped", {31'h0, irq}, 32'h0);
        wr(S_PEND, 4'hF, 32'hFFFF_FFFF);
    endtask

    task automatic t_extended;
        logic [31:0] d;
        point(2'd0, 12'h075); wr(S_DATA, 4'hF, 32'h0000_0010);
        rd(S_DATA, d); check("R8 mask read back", d, 32'h0000_0010);
        ext_pulse(32'h0000_0001);
        rd(S_PEND, d); check("R9 unmasked event no summary", d, 32'h0);
        point(2'd0, 12'h076); rd(S_DATA, d); check("R8 status set", d, 32'h0000_0001);
        ext_pulse(32'h0000_0010);
        rd(S_PEND, d); check("R9 masked event sets summary", d, 32'h0000_0100);
        rd(S_DATA, d); check("R8 status accumulates", d, 32'h0000_0011);
        wr(S_DATA, 4'hF, 32'h0000_0001);
        rd(S_DATA, d); check("R8 status clear", d, 32'h0000_0010);
        @(negedge clk);
        ext_evt = 32'h0000_0010;
        bus_wr = 1'b1; bus_sel = S_DATA; bus_be = 4'hF; bus_wdata = 32'h0000_0010;
        @(posedge clk); #1;
        ext_evt = '0; bus_wr = 1'b0;
        rd(S_DATA, d); check("R8 event beats status clear", d, 32'h0000_0010);
        wr(S_PEND, 4'hF, 32'h0000_0100);
        rd(S_PEND, d); check("R9 summary cleared", d, 32'h0);
    endtask

    task automatic t_read_hold;
        logic [31:0] d;
        point(2'd1, 12'h00A);
        rd(S_PTR, d); check("R12 read value", d, 32'h000A_0001);
        point(2'd2, 12'h011);
        hw_pulse(32'h0000_0004);
        check("R12 rdata holds without strobe", bus_rdata, 32'h000A_0001);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_pointer();
        t_data();
        t_unimpl();
        t_pending();
        t_set_wins();
        t_enable_irq();
        t_extended();
        t_read_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule